// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block moves a byte stream between a local sector buffer and host memory. The host memory regions are listed in a table of 8-byte descriptors. Software loads the table base through a one-word register write, then pulses `start`. The walker reads descriptors one at a time on a descriptor-read port. It splits each region into data bursts and issues them on a transfer-command port. The `dir` input sets the direction of the bursts. Each burst command carries the host address, the byte count and the offset in the local buffer.

A walk ends in one of two ways. It ends with `done` when the buffer has been fully moved. It ends with `incomplete` when the table runs out first. The table runs out either on a descriptor flagged as last, or once the pointer is a full table page past the base. When `start` is raised with `resume` set, the walker continues from the partly used region and the next descriptor pointer of the previous walk. It is used this way when one table serves several buffer loads.

The state machine has seven states:
- IDLE waits for `start`, which leads to CHECK.
- CHECK decides the next step. With no buffer bytes left it goes to DONE. With the region empty and the table exhausted it goes to SHORT. With the region empty and the table not exhausted it goes to FETCH_REQ. Otherwise it goes to MOVE.
- FETCH_REQ holds the descriptor request and goes to FETCH_WAIT once the request is accepted.
- FETCH_WAIT decodes the response and returns to CHECK.
- MOVE holds a burst command and returns to CHECK once the command is accepted.
- DONE and SHORT each last one cycle and then return to IDLE.

Top module: `sg_walker`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `incomplete`, `desc_req_valid` and `xfer_valid` are all 0. The two request valids stay 0 whenever `busy` is 0.
- R2: `base_wr` loads `base_data` with bits 1:0 forced to zero. The first descriptor of a fresh walk is read at that aligned base.
- R3: A descriptor response carries the region address in bits 31:0. Its length is bits 47:32 ANDed with 0xFFFE, so bit 32 is ignored. Bits 62:48 have no effect.
- R4: A decoded length of zero means a region of 65536 bytes.
- R5: Each descriptor fetch advances the descriptor pointer by 8. A new descriptor is fetched only when the current region has no bytes left.
- R6: Each burst length is the smallest of three values: the buffer bytes left, the region bytes left and MAX_BURST (64). After each burst, the region address and the buffer offset advance by the burst length, and the region bytes left drop by the same amount.
- R7: Bit 63 of a descriptor marks it as the last one. When its region is used up while buffer bytes remain, the walk ends with a one-cycle `incomplete` and makes no further fetch.
- R8: When the pointer is TABLE_LIMIT (4096) or more bytes past the base, no further descriptor is fetched. If buffer bytes remain, the walk ends with `incomplete`.
- R9: When the buffer bytes reach zero, the walk ends with a one-cycle `done`. A walk started with `resume`=1 continues with the partly used region and the saved descriptor pointer.
- R10: A start with `resume`=0 clears the region address, the region length and the last flag, and reloads the pointer from the base.
- R11: A request held without ready keeps its valid and its fields stable. At most one descriptor read is outstanding. A descriptor request and a burst command are never valid in the same cycle.
- R12: `xfer_write` equals the `dir` value captured at start for every burst of that walk.
- R13: A start with `buf_bytes`=0 ends with `done` without any fetch or burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_wr | input | 1 | Load the table base register |
| base_data | input | 32 | Table base value to load |
| start | input | 1 | Begin a walk; accepted only in IDLE |
| resume | input | 1 | With start: keep pointer and region from the previous walk |
| dir | input | 1 | Direction captured at start; 1 means write to host memory |
| buf_bytes | input | BUF_W (17) | Bytes to move in this walk |
| desc_req_valid | output | 1 | Descriptor read request |
| desc_req_ready | input | 1 | Descriptor request accepted |
| desc_req_addr | output | 32 | Address of the 8-byte descriptor |
| desc_rsp_valid | input | 1 | Descriptor data valid |
| desc_rsp_data | input | 64 | Descriptor, little-endian words |
| xfer_valid | output | 1 | Burst command valid |
| xfer_ready | input | 1 | Burst command accepted |
| xfer_addr | output | 32 | Host address of the burst |
| xfer_len | output | CHUNK_W (7) | Burst byte count |
| xfer_buf_off | output | BUF_W (17) | Local buffer offset of the burst |
| xfer_write | output | 1 | Burst direction |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: buffer fully moved |
| incomplete | output | 1 | One-cycle pulse: table ended with bytes left |

## Verification
The walker is tried against three descriptor tables, each separating a different failure:
- A short flagged table with an odd length and stray high flag bits. It shows whether burst splitting takes the minimum of the three limits in the right order, and whether the even-length mask and the ignored flag bits are honoured.
- One zero-length last descriptor. It is given more than 64 KiB of buffer, which separates the 65536-byte reading from a zero-byte one.
- An unterminated table of 2-byte regions. It exercises the one-page fetch limit, since a missing or off-by-one limit changes the fetch count away from 512.

A resumed walk followed by a fresh walk on the same table shows whether saved region state is kept or cleared as asked. A zero-byte buffer, an exact-fit buffer and both directions cover the edges of end detection.

// File: rtl/sg_walker_pkg.sv
package sg_walker_pkg;

    localparam int DESC_ADDR_W = 32;
    localparam int REGION_W    = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_MOVE,
        ST_DONE,
        ST_SHORT
    } walk_state_t;

    typedef struct packed {
        logic [DESC_ADDR_W-1:0] addr;
        logic [REGION_W-1:0]    len;
        logic                   last;
    } region_t;

endpackage

// File: rtl/sg_desc_decode.sv
module sg_desc_decode
    import sg_walker_pkg::*;
(
    input  logic [63:0] word,
    output region_t     region
);
    logic [15:0] masked;

    always_comb begin
        masked      = word[47:32] & 16'hFFFE;
        region.addr = word[31:0];
        region.last = word[63];
        if (masked == 16'h0000) begin
            region.len = REGION_W'(17'h10000);
        end else begin
            region.len = REGION_W'(masked);
        end
    end
endmodule

// File: rtl/sg_chunk_calc.sv
module sg_chunk_calc #(
    parameter int BUF_W     = 17,
    parameter int REGION_W  = 17,
    parameter int MAX_BURST = 64,
    localparam int CHUNK_W  = $clog2(MAX_BURST + 1)
) (
    input  logic [BUF_W-1:0]    buf_left,
    input  logic [REGION_W-1:0] reg_left,
    output logic [CHUNK_W-1:0]  chunk
);
    localparam int CMP_W = ((BUF_W > REGION_W) ? BUF_W : REGION_W) + 1;

    logic [CMP_W-1:0] a_w, b_w, m_w;

    always_comb begin
        a_w = CMP_W'(buf_left);
        b_w = CMP_W'(reg_left);
        m_w = (a_w < b_w) ? a_w : b_w;
        if (m_w > CMP_W'(MAX_BURST)) begin
            m_w = CMP_W'(MAX_BURST);
        end
        chunk = CHUNK_W'(m_w);
    end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sg_walker_pkg::*;
#(
    parameter int BUF_W       = 17,
    parameter int MAX_BURST   = 64,
    parameter int TABLE_LIMIT = 4096,
    parameter int DESC_BYTES  = 8,
    localparam int CHUNK_W    = $clog2(MAX_BURST + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   base_wr,
    input  logic [DESC_ADDR_W-1:0] base_data,
    input  logic                   start,
    input  logic                   resume,
    input  logic                   dir,
    input  logic [BUF_W-1:0]       buf_bytes,
    output logic                   desc_req_valid,
    input  logic                   desc_req_ready,
    output logic [DESC_ADDR_W-1:0] desc_req_addr,
    input  logic                   desc_rsp_valid,
    input  logic [63:0]            desc_rsp_data,
    output logic                   xfer_valid,
    input  logic                   xfer_ready,
    output logic [DESC_ADDR_W-1:0] xfer_addr,
    output logic [CHUNK_W-1:0]     xfer_len,
    output logic [BUF_W-1:0]       xfer_buf_off,
    output logic                   xfer_write,
    output logic                   busy,
    output logic                   done,
    output logic                   incomplete
);
    walk_state_t            state_q, state_d;
    logic [DESC_ADDR_W-1:0] base_q, ptr_q;
    region_t                cur_q, decoded;
    logic [BUF_W-1:0]       left_q, off_q;
    logic                   write_q;
    logic [CHUNK_W-1:0]     chunk;
    logic                   table_end;

    sg_desc_decode u_decode (
        .word   (desc_rsp_data),
        .region (decoded)
    );

    sg_chunk_calc #(
        .BUF_W     (BUF_W),
        .REGION_W  (REGION_W),
        .MAX_BURST (MAX_BURST)
    ) u_chunk (
        .buf_left (left_q),
        .reg_left (cur_q.len),
        .chunk    (chunk)
    );

    assign table_end = cur_q.last ||
                       ((ptr_q - base_q) >= DESC_ADDR_W'(TABLE_LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (left_q == '0) begin
                    state_d = ST_DONE;
                end else if (cur_q.len == '0) begin
                    state_d = table_end ? ST_SHORT : ST_FETCH_REQ;
                end else begin
                    state_d = ST_MOVE;
                end
            end
            ST_FETCH_REQ:  if (desc_req_ready) state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: if (desc_rsp_valid) state_d = ST_CHECK;
            ST_MOVE:       if (xfer_ready) state_d = ST_CHECK;
            ST_DONE:       state_d = ST_IDLE;
            ST_SHORT:      state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            ptr_q   <= '0;
            cur_q   <= '0;
            left_q  <= '0;
            off_q   <= '0;
            write_q <= 1'b0;
        end else begin
            if (base_wr) begin
                base_q <= {base_data[DESC_ADDR_W-1:2], 2'b00};
            end
            if (state_q == ST_IDLE && start) begin
                left_q  <= buf_bytes;
                off_q   <= '0;
                write_q <= dir;
                if (!resume) begin
                    ptr_q <= base_q;
                    cur_q <= '0;
                end
            end
            if (state_q == ST_FETCH_WAIT && desc_rsp_valid) begin
                cur_q <= decoded;
                ptr_q <= ptr_q + DESC_ADDR_W'(DESC_BYTES);
            end
            if (state_q == ST_MOVE && xfer_ready) begin
                cur_q.addr <= cur_q.addr + DESC_ADDR_W'(chunk);
                cur_q.len  <= cur_q.len - REGION_W'(chunk);
                left_q     <= left_q - BUF_W'(chunk);
                off_q      <= off_q + BUF_W'(chunk);
            end
        end
    end

    always_comb begin
        busy           = (state_q != ST_IDLE) && (state_q != ST_DONE) &&
                         (state_q != ST_SHORT);
        done           = (state_q == ST_DONE);
        incomplete     = (state_q == ST_SHORT);
        desc_req_valid = (state_q == ST_FETCH_REQ);
        desc_req_addr  = ptr_q;
        xfer_valid     = (state_q == ST_MOVE);
        xfer_addr      = cur_q.addr;
        xfer_len       = chunk;
        xfer_buf_off   = off_q;
        xfer_write     = write_q;
    end
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
    parameter int BUF_W     = 17,
    parameter int MAX_BURST = 64,
    localparam int CHUNK_W  = $clog2(MAX_BURST + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               desc_req_valid,
    input logic               desc_req_ready,
    input logic [31:0]        desc_req_addr,
    input logic               xfer_valid,
    input logic               xfer_ready,
    input logic [31:0]        xfer_addr,
    input logic [CHUNK_W-1:0] xfer_len,
    input logic [BUF_W-1:0]   xfer_buf_off,
    input logic               busy,
    input logic               done,
    input logic               incomplete
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!desc_req_valid && !xfer_valid));

    p_desc_align_r2: assert property (@(posedge clk) disable iff (rst)
        desc_req_valid |-> (desc_req_addr[1:0] == 2'b00));

    p_chunk_cap_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> ((xfer_len != '0) && (xfer_len <= CHUNK_W'(MAX_BURST))));

    p_status_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && incomplete));

    p_status_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (done || incomplete) |=> !(done || incomplete));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (desc_req_valid && !desc_req_ready) |=>
            (desc_req_valid && $stable(desc_req_addr)));

    p_xfer_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_ready) |=>
            (xfer_valid && $stable(xfer_addr) && $stable(xfer_len) &&
             $stable(xfer_buf_off)));

    p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
        !(desc_req_valid && xfer_valid));

    p_single_fetch_r11: assert property (@(posedge clk) disable iff (rst)
        (desc_req_valid && desc_req_ready) |=> (!desc_req_valid && !xfer_valid));
endmodule

bind sg_walker sg_walker_chk #(
    .BUF_W     (BUF_W),
    .MAX_BURST (MAX_BURST)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .desc_req_valid (desc_req_valid),
    .desc_req_ready (desc_req_ready),
    .desc_req_addr  (desc_req_addr),
    .xfer_valid     (xfer_valid),
    .xfer_ready     (xfer_ready),
    .xfer_addr      (xfer_addr),
    .xfer_len       (xfer_len),
    .xfer_buf_off   (xfer_buf_off),
    .busy           (busy),
    .done           (done),
    .incomplete     (incomplete)
);

// File: tb/tb_sg_walker.sv
module tb_sg_walker;
    localparam int BUF_W   = 17;
    localparam int CHUNK_W = 7;
    localparam int LOG_N   = 1100;

    logic               clk = 1'b0;
    logic               rst;
    logic               base_wr;
    logic [31:0]        base_data;
    logic               start;
    logic               resume;
    logic               dir;
    logic [BUF_W-1:0]   buf_bytes;
    logic               desc_req_valid;
    logic               desc_req_ready;
    logic [31:0]        desc_req_addr;
    logic               desc_rsp_valid;
    logic [63:0]        desc_rsp_data;
    logic               xfer_valid;
    logic               xfer_ready;
    logic [31:0]        xfer_addr;
    logic [CHUNK_W-1:0] xfer_len;
    logic [BUF_W-1:0]   xfer_buf_off;
    logic               xfer_write;
    logic               busy;
    logic               done;
    logic               incomplete;

    always #5 clk = ~clk;

    sg_walker dut (
        .clk(clk), .rst(rst), .base_wr(base_wr), .base_data(base_data),
        .start(start), .resume(resume), .dir(dir), .buf_bytes(buf_bytes),
        .desc_req_valid(desc_req_valid), .desc_req_ready(desc_req_ready),
        .desc_req_addr(desc_req_addr), .desc_rsp_valid(desc_rsp_valid),
        .desc_rsp_data(desc_rsp_data), .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_buf_off(xfer_buf_off), .xfer_write(xfer_write), .busy(busy),
        .done(done), .incomplete(incomplete)
    );

    int checks = 0;
    int errors = 0;
    int tab_mode = 0;
    logic [31:0] base_eff = 32'h0000_8000;

    // Observed activity
    int          g_n, fetch_n, wrong_dir;
    logic [31:0] first_fetch;
    logic [31:0] g_addr [LOG_N];
    int          g_len  [LOG_N];
    int          g_off  [LOG_N];
    logic        cur_dir;

    // Reference model state kept across walks for resume
    logic [31:0] r_ptr, r_addr;
    int          r_len;
    logic        r_last;
    int          e_n, e_fetch, e_short;
    logic [31:0] e_addr [LOG_N];
    int          e_len  [LOG_N];
    int          e_off  [LOG_N];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] desc_word(input logic [31:0] a);
        int idx;
        logic [31:0] w0, w1;
        idx = int'((a - base_eff) >> 3);
        case (tab_mode)
            0: begin
                w0 = 32'h1000_0000 + 32'(idx) * 32'h100;
                case (idx)
                    0:       w1 = 32'h4000_0064;
                    1:       w1 = 32'h0000_0025;
                    default: w1 = 32'h8000_00C8;
                endcase
            end
            1: begin
                w0 = 32'h2000_0000;
                w1 = 32'h8000_0000;
            end
            default: begin
                w0 = 32'h3000_0000 + 32'(idx) * 32'h10;
                w1 = 32'h0000_0003;
            end
        endcase
        return {w1, w0};
    endfunction

    task automatic ref_walk(input int nbytes, input bit res);
        int rem, off, c;
        logic [63:0] w;
        if (!res) begin
            r_ptr = base_eff; r_addr = '0; r_len = 0; r_last = 1'b0;
        end
        rem = nbytes; off = 0; e_n = 0; e_fetch = 0; e_short = 0;
        forever begin
            if (rem == 0) break;
            if (r_len == 0) begin
                if (r_last || ((r_ptr - base_eff) >= 32'd4096)) begin
                    e_short = 1;
                    break;
                end
                w = desc_word(r_ptr);
                r_ptr = r_ptr + 8;
                e_fetch++;
                r_addr = w[31:0];
                r_len = int'(w[47:32] & 16'hFFFE);
                if (r_len == 0) r_len = 65536;
                r_last = w[63];
            end else begin
                c = rem;
                if (r_len < c) c = r_len;
                if (c > 64) c = 64;
                e_addr[e_n] = r_addr; e_len[e_n] = c; e_off[e_n] = off;
                e_n++;
                r_addr = r_addr + 32'(c);
                r_len -= c; rem -= c; off += c;
            end
        end
    endtask

    // Memory-side responders
    logic [31:0] lat_addr;
    bit          stall_ph;
    initial begin
        desc_req_ready = 1'b0; desc_rsp_valid = 1'b0; desc_rsp_data = '0;
        xfer_ready = 1'b0; lat_addr = '0; stall_ph = 1'b0;
        forever begin
            @(negedge clk);
            desc_rsp_valid = 1'b0;
            xfer_ready = 1'b0;
            if (desc_req_ready) begin
                desc_req_ready = 1'b0;
                desc_rsp_valid = 1'b1;
                desc_rsp_data  = desc_word(lat_addr);
            end else if (desc_req_valid) begin
                desc_req_ready = 1'b1;
                lat_addr = desc_req_addr;
                if (fetch_n == 0) first_fetch = desc_req_addr;
                fetch_n++;
            end
            if (xfer_valid) begin
                stall_ph = ~stall_ph;
                if (stall_ph) begin
                    xfer_ready = 1'b1;
                    if (g_n < LOG_N) begin
                        g_addr[g_n] = xfer_addr;
                        g_len[g_n]  = int'(xfer_len);
                        g_off[g_n]  = int'(xfer_buf_off);
                    end
                    if (xfer_write != cur_dir) wrong_dir++;
                    g_n++;
                end
            end
        end
    end

    task automatic walk(input string req, input int mode, input int nbytes,
                        input bit res, input bit d);
        int  cyc, bad;
        bit  got_done, got_short;
        tab_mode = mode;
        ref_walk(nbytes, res);
        g_n = 0; fetch_n = 0; wrong_dir = 0; first_fetch = '0; cur_dir = d;
        @(negedge clk);
        start = 1'b1; resume = res; dir = d; buf_bytes = BUF_W'(nbytes);
        @(negedge clk);
        start = 1'b0; resume = 1'b0;
        got_done = 0; got_short = 0; cyc = 0;
        while (!got_done && !got_short && cyc < 20000) begin
            @(negedge clk);
            got_done = done; got_short = incomplete;
            cyc++;
        end
        check(cyc < 20000, req, "watchdog cycles", cyc, 20000);
        check(got_short == bit'(e_short) && got_done == !bit'(e_short), req,
              "end status incomplete", longint'(got_short), longint'(e_short));
        check(g_n == e_n, req, "burst count", g_n, e_n);
        bad = -1;
        for (int i = 0; i < e_n && i < g_n && i < LOG_N; i++) begin
            if (bad < 0 && (g_addr[i] != e_addr[i] || g_len[i] != e_len[i] ||
                            g_off[i] != e_off[i])) bad = i;
        end
        if (bad >= 0)
            check(1'b0, req, $sformatf("burst %0d addr/len/off %h/%0d/%0d exp len/off", bad,
                  g_addr[bad], g_len[bad], g_off[bad]), g_len[bad], e_len[bad]);
        else
            check(1'b1, req, "burst contents", 0, 0);
        check(fetch_n == e_fetch, req, "descriptor fetches", fetch_n, e_fetch);
        check(wrong_dir == 0, "R12", "bursts with wrong direction", wrong_dir, 0);
        @(negedge clk);
        check(!busy && !done && !incomplete, req, "idle after end", busy, 0);
    endtask

    initial begin
        rst = 1'b1; base_wr = 1'b0; base_data = '0; start = 1'b0;
        resume = 1'b0; dir = 1'b0; buf_bytes = '0;
        g_n = 0; fetch_n = 0; wrong_dir = 0; cur_dir = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !incomplete && !desc_req_valid && !xfer_valid,
              "R1", "outputs after reset", {busy, done, incomplete}, 0);

        // R2: base with low bits set is aligned
        base_wr = 1'b1; base_data = 32'h0000_8003;
        @(negedge clk);
        base_wr = 1'b0;

        // R3 R6: odd length masked, high flag bits ignored, three-way minimum
        walk("R6", 0, 300, 1'b0, 1'b1);
        check(first_fetch == 32'h0000_8000, "R2", "first descriptor address",
              first_fetch, 32'h8000);
        // R9: resume continues partly used last region, then R7 ends short
        walk("R9", 0, 50, 1'b1, 1'b0);
        // R10: fresh start clears region; exact fit ends with done
        walk("R10", 0, 336, 1'b0, 1'b0);
        check(fetch_n == 3, "R3", "exact fit fetches", fetch_n, 3);
        // R7: last flag with bytes left
        walk("R7", 0, 400, 1'b0, 1'b1);
        // R4: zero length means 65536 bytes
        walk("R4", 1, 65636, 1'b0, 1'b1);
        // R8 R5: unterminated table stops at one page
        walk("R8", 2, 2000, 1'b0, 1'b0);
        check(fetch_n == 512, "R5", "page limit fetches", fetch_n, 512);
        // R13: empty buffer
        walk("R13", 0, 0, 1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule